// File: doc/BRIEF.md
# Iterative Binary Logarithm Unit

This block computes the base-2 logarithm of an unsigned integer operand using a fixed sequence of steps. A one-cycle start strobe loads the operand. A leading-zero binary search then normalizes the operand one stage per cycle. The search halves its field width at each stage and leaves the most significant bit set. The unit then squares the normalized value repeatedly and takes one fraction bit per cycle. The bit is set when the square reaches two.

The result is an unsigned fixed-point number. The integer part (the characteristic) sits in the upper bits and the truncated fraction fills the lower bits. An operand of zero has no logarithm. For a zero operand the unit skips the computation, returns zero and raises an error flag. Callers wait for the one-cycle done pulse and then read the result, which stays unchanged until another operation completes.

Top module: `log2_iter`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low and result_o is zero.
- R2: A start with operand zero returns result_o = 0 with err_o = 1 and a done_o pulse right after the sampling edge; busy_o stays low throughout.
- R3: err_o goes low on the edge that samples the next accepted start, and stays low for a nonzero operand.
- R4: result_o[31:27] holds the bit index of the most significant set bit of the operand (0 for operand 1, 31 for operands of 2^31 and above).
- R5: result_o[26:0] is the truncated fraction. Shift the operand left until bit 31 is set, then iterate 27 times. Each iteration squares the value and keeps the upper 32 bits of the 64-bit product. If bit 31 of that value is set, the next fraction bit (MSB first) is 1 and the value is kept. Otherwise the bit is 0 and the value shifts left by one.
- R6: An operand that is an exact power of two yields an all-zero fraction field.
- R7: For a nonzero operand, done_o appears after exactly 33 rising edges, counting the edge that samples start_i. busy_o is high from the edge after the sampling edge until the edge that raises done_o, and done_o is never high while busy_o is high.
- R8: done_o lasts exactly one cycle. result_o changes only on the edge that raises done_o and otherwise holds its value.
- R9: A start_i pulse while busy_o is high is ignored: the running operation completes with the result for its original operand and at its original time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| operand_i | input | 32 | Unsigned operand, sampled with start_i |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Characteristic in [31:27], fraction in [26:0] |
| err_o | output | 1 | Operand was zero; set with done_o |

## Verification
The bench builds the unit with its default 32-bit width, which gives a 5-bit characteristic and a 27-bit fraction. At that width a complete operation takes only 33 cycles, so every shift stage of the leading-zero search can be exercised: operands range from 1 up to all ones, and the powers of two are placed so that each stage's field is sometimes zero and sometimes not. The same short latency allows exact checks of the cycle count, of a start issued in the middle of an operation, and of the error path followed by a normal operation.

// File: rtl/log2_pkg.sv
package log2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_SQR  = 2'd2
  } lg_state_e;
endpackage

// File: rtl/log2_ctrl.sv
module log2_ctrl
  import log2_pkg::*;
#(
  parameter int CHAR_W = 5,
  parameter int FRAC_W = 27,
  localparam int MAX_N = (FRAC_W > CHAR_W) ? FRAC_W : CHAR_W,
  localparam int CNT_W = $clog2(MAX_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             zero_i,
  output logic             accept_o,
  output logic             norm_en_o,
  output logic             sqr_en_o,
  output logic             last_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  lg_state_e  state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign norm_en_o = (state_q == ST_NORM);
  assign sqr_en_o  = (state_q == ST_SQR);
  assign last_o    = sqr_en_o && (cnt_q == CNT_W'(FRAC_W - 1));
  assign busy_o    = (state_q != ST_IDLE);
  assign cnt_o     = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i && !zero_i) state_d = ST_NORM;
      end
      ST_NORM: begin
        if (cnt_q == CNT_W'(CHAR_W - 1)) begin
          state_d = ST_SQR;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SQR: begin
        if (cnt_q == CNT_W'(FRAC_W - 1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/log2_norm_step.sv
module log2_norm_step #(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 5,
  localparam int STG_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [CHAR_W-1:0] chr_i,
  input  logic [STG_W-1:0]  stage_i,
  output logic [DATA_W-1:0] val_o,
  output logic [CHAR_W-1:0] chr_o
);
  logic [DATA_W-1:0] cand_val [CHAR_W];
  logic [CHAR_W-1:0] cand_chr [CHAR_W];

  // stage k inspects the top DATA_W>>(k+1) bits
  for (genvar k = 0; k < CHAR_W; k++) begin : g_stage
    localparam int SH = DATA_W >> (k + 1);
    logic top_zero;
    assign top_zero    = ~|val_i[DATA_W-1 -: SH];
    assign cand_val[k] = top_zero ? (val_i << SH) : val_i;
    assign cand_chr[k] = top_zero ? (chr_i - CHAR_W'(SH)) : chr_i;
  end

  always_comb begin
    val_o = val_i;
    chr_o = chr_i;
    for (int k = 0; k < CHAR_W; k++) begin
      if (stage_i == STG_W'(k)) begin
        val_o = cand_val[k];
        chr_o = cand_chr[k];
      end
    end
  end
endmodule

// File: rtl/log2_sqr_step.sv
module log2_sqr_step #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] val_o,
  output logic              bit_o
);
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0]   hi;

  assign prod  = {{DATA_W{1'b0}}, val_i} * {{DATA_W{1'b0}}, val_i};
  assign hi    = prod[2*DATA_W-1:DATA_W];
  // square reached two: keep value, emit a one
  assign bit_o = hi[DATA_W-1];
  assign val_o = bit_o ? hi : (hi << 1);
endmodule

// File: rtl/log2_iter.sv
module log2_iter
  import log2_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CHAR_W = $clog2(DATA_W),
  localparam int FRAC_W = DATA_W - CHAR_W,
  localparam int STG_W  = (CHAR_W > 1) ? $clog2(CHAR_W) : 1,
  localparam int MAX_N  = (FRAC_W > CHAR_W) ? FRAC_W : CHAR_W,
  localparam int CNT_W  = $clog2(MAX_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              err_o
);
  logic              zero_op;
  logic              accept, norm_en, sqr_en, last;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] val_q, norm_val, sqr_val;
  logic [CHAR_W-1:0] chr_q, norm_chr;
  logic [FRAC_W-1:0] frac_q, frac_next;
  logic              sqr_bit;

  assign zero_op = ~|operand_i;

  log2_ctrl #(.CHAR_W(CHAR_W), .FRAC_W(FRAC_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .zero_i    (zero_op),
    .accept_o  (accept),
    .norm_en_o (norm_en),
    .sqr_en_o  (sqr_en),
    .last_o    (last),
    .busy_o    (busy_o),
    .cnt_o     (cnt)
  );

  log2_norm_step #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_norm (
    .val_i   (val_q),
    .chr_i   (chr_q),
    .stage_i (cnt[STG_W-1:0]),
    .val_o   (norm_val),
    .chr_o   (norm_chr)
  );

  log2_sqr_step #(.DATA_W(DATA_W)) u_sqr (
    .val_i (val_q),
    .val_o (sqr_val),
    .bit_o (sqr_bit)
  );

  assign frac_next = {frac_q[FRAC_W-2:0], sqr_bit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q    <= '0;
      chr_q    <= '0;
      frac_q   <= '0;
      result_o <= '0;
      err_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        val_q  <= operand_i;
        chr_q  <= CHAR_W'(DATA_W - 1);
        frac_q <= '0;
        err_o  <= zero_op;
        if (zero_op) begin
          result_o <= '0;
          done_o   <= 1'b1;
        end
      end else if (norm_en) begin
        val_q <= norm_val;
        chr_q <= norm_chr;
      end else if (sqr_en) begin
        val_q  <= sqr_val;
        frac_q <= frac_next;
        if (last) begin
          result_o <= {chr_q, frac_next};
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/log2_iter_chk.sv
module log2_iter_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic              err_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));  // R8
  AST_NO_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);  // R7
  AST_BUSY_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);  // R7
  AST_BUSY_KEEP_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(result_o) || done_o));  // R9
  AST_ERR_ZERO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (result_o == '0));  // R2
  AST_ERR_RISE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (done_o && !busy_o));  // R2
  AST_ERR_QUIET_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !err_o);  // R3
endmodule

bind log2_iter log2_iter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .err_o    (err_o)
);

// File: tb/log2_iter_test.sv
`timescale 1ns/1ps
module log2_iter_test;
  localparam int DW = 32;
  localparam int NV = 7;
  // {operand, expected result} for exact powers of two
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0001, 32'h0000_0000},
    {32'h0000_0002, 32'h0800_0000},
    {32'h0000_0004, 32'h1000_0000},
    {32'h0000_0100, 32'h4000_0000},
    {32'h0001_0000, 32'h8000_0000},
    {32'h0040_0000, 32'hB000_0000},
    {32'h8000_0000, 32'hF800_0000}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] operand_i = '0;
  logic          busy_o, done_o, err_o;
  logic [DW-1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  log2_iter #(.DATA_W(DW)) uut (
    .clk_i, .rst_ni, .start_i, .operand_i,
    .busy_o, .done_o, .result_o, .err_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] x);
    int msb = 0;
    logic [31:0] v;
    logic [63:0] p;
    logic [26:0] f = '0;
    for (int b = 0; b < 32; b++) if (x[b]) msb = b;
    v = x << (31 - msb);
    for (int it = 0; it < 27; it++) begin
      p = {32'd0, v} * {32'd0, v};
      v = p[63:32];
      f = {f[25:0], v[31]};
      if (!v[31]) v = v << 1;
    end
    return {msb[4:0], f};
  endfunction

  // launch op, return result, err and edge count incl. sampling edge
  task automatic run_op(input logic [31:0] op, output logic [31:0] res,
                        output logic err, output int lat);
    @(negedge clk_i);
    operand_i = op;
    start_i   = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    if (!done_o) chk("R7 done timeout", 0, 1);
    res = result_o;
    err = err_o;
    @(negedge clk_i);
    chk("R8 done single cycle", done_o, 0);
    chk("R8 result held", result_o, res);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] res;
    logic        err;
    int          lat;
    logic [31:0] pats [10] = '{32'd3, 32'd5, 32'd7, 32'd10, 32'd1000, 32'h1234_5678,
                               32'hFFFF_FFFF, 32'h0001_0001, 32'h7FFF_FFFF, 32'h0000_FFFF};

    #35;
    chk("R1 busy reset", busy_o, 0);
    chk("R1 done reset", done_o, 0);
    chk("R1 err reset", err_o, 0);
    chk("R1 result reset", result_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R6 R4: exact powers of two
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][63:32], res, err, lat);
      chk("R6 power of two result", res, VEC[i][31:0]);
      chk("R4 characteristic", res[31:27], VEC[i][31:27]);
      chk("R7 latency", lat, 33);
    end

    // R5 R4: general operands
    foreach (pats[i]) begin
      logic [31:0] e;
      e = model(pats[i]);
      run_op(pats[i], res, err, lat);
      chk("R5 fraction", res, e);
      chk("R4 characteristic", res[31:27], e[31:27]);
      chk("R3 err low nonzero", err, 0);
      chk("R7 latency", lat, 33);
    end

    // R2: zero operand
    run_op(32'd0, res, err, lat);
    chk("R2 zero result", res, 0);
    chk("R2 zero err", err, 1);
    chk("R2 zero latency", lat, 1);
    chk("R2 zero busy", busy_o, 0);

    // R3: err cleared by next start
    @(negedge clk_i);
    operand_i = 32'd6;
    start_i   = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R3 err cleared at start", err_o, 0);
    chk("R7 busy after start", busy_o, 1);
    while (!done_o) @(negedge clk_i);
    chk("R3 result after error", result_o, model(32'd6));

    // R9: start during busy ignored
    @(negedge clk_i);
    operand_i = 32'd12;
    start_i   = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    operand_i = 32'h0000_0000;
    lat = 1;
    repeat (10) begin
      @(negedge clk_i);
      lat++;
    end
    @(negedge clk_i);
    lat++;
    start_i = 1'b0;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      lat++;
    end
    chk("R9 result of original op", result_o, model(32'd12));
    chk("R9 err unaffected", err_o, 0);
    chk("R9 latency unchanged", lat, 33);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule